// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a scratchpad split into interleaved banks. It serves a group of lane requests that arrive together as one access. Each lane has a valid bit, a word address, a write enable and write data. The low address bits pick the bank and the upper bits pick the row inside that bank.

Each cycle, every bank serves one word. Lanes that target the same bank at different words are spread over several cycles. Lanes that target the same word are merged into one access. A read from that word is returned to every lane that asked for it. The requester holds its group while `busy_o` is high. `done_o` marks the cycle in which the read data for the whole group is available.

The cost of a group is the largest number of distinct words that any single bank must deliver. With the default sizes, a half-warp of 16 lanes is served by 16 banks of 32-bit words.

Top module: `smem_bank_arb`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and every lane of `rd_data_o` is zero.
- R2: The bank of a word is its address modulo BANKS, which is the low log2(BANKS) address bits. The row inside the bank is the remaining upper bits. A group of consecutive addresses touches every bank once and is served in one busy cycle.
- R3: A group is accepted at a clock edge where `req_i` is high and `busy_o` is low. `busy_o` is then high for exactly N cycles, where N is the largest count of distinct words addressed by valid lanes in any one bank, or 1 if that count is 0. `done_o` is a one-cycle pulse in the cycle right after the last busy cycle, and `busy_o` is low in that cycle.
- R4: Valid lanes that read the same word are merged into a single access. When all lanes read one address, the group takes one cycle and every lane returns that word.
- R5: Addresses spaced by an odd stride cost 1 cycle. A stride of 2 costs 2 cycles and a stride of 8 costs 8 cycles.
- R6: When two or more lanes of a group write the same word, the value from the highest-index writing lane is stored.
- R7: A lane that reads a word in the same group as a write to that word returns the value the word held before the group.
- R8: From `done_o` until the next accepted group, every valid read lane of `rd_data_o` holds its word. Write lanes and invalid lanes read zero.
- R9: `req_i` is ignored while `busy_o` is high. The group presented then writes nothing and does not change the group in flight.
- R10: Invalid lanes do not access memory and add nothing to the cycle cost. A group with no valid lane takes one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Present a group; taken when `busy_o` is low |
| lane_vld_i | input | LANES | Per-lane valid |
| lane_addr_i | input | LANES x AW | Per-lane word address |
| lane_we_i | input | LANES | Per-lane write enable |
| lane_wdata_i | input | LANES x DW | Per-lane write data |
| busy_o | output | 1 | Group in service; requester stalls |
| done_o | output | 1 | One-cycle pulse; read data valid |
| rd_data_o | output | LANES x DW | Per-lane read data |

## Verification
Unit-stride and odd-stride groups, where every lane falls in a different bank, show that no cycles are added. Strides of 2 and 8 give 2-way and 8-way conflicts, and they show that the cycle count follows the worst bank rather than the number of lanes. A broadcast group and a group with two writers to one word separate merging of same-word lanes from plain serialization. They also pin down which write is stored. Masked groups whose invalid lanes carry conflicting addresses, a read that shares a word with a write, and a request raised during a long group show that invalid lanes and stalled requests have no effect.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int unsigned DEF_LANES = 16;
  localparam int unsigned DEF_BANKS = 16;
  localparam int unsigned DEF_DW    = 32;
  localparam int unsigned DEF_AW    = 10;
endpackage

// File: rtl/smem_bank_ram.sv
module smem_bank_ram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned RW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [RW-1:0] row_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  // Asynchronous read: returns the value held before this cycle's write
  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/smem_bank_sel.sv
module smem_bank_sel #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned AW      = 10,
  parameter int unsigned DW      = 32,
  parameter int unsigned BBITS   = 4,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned RW     = AW - BBITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [LANES-1:0]           pend_i,
  input  logic [LANES-1:0][AW-1:0]   addr_i,
  input  logic [LANES-1:0]           we_i,
  input  logic [LANES-1:0][DW-1:0]   wdata_i,
  output logic                       acc_o,
  output logic [RW-1:0]              row_o,
  output logic [LANES-1:0]           served_o,
  output logic                       wr_o,
  output logic [DW-1:0]              wdata_o
);
  logic [LANES-1:0] hit;
  logic [LANES-1:0] wsel;
  logic [AW-1:0]    word;

  always_comb begin
    hit  = '0;
    acc_o = 1'b0;
    word = '0;
    for (int l = 0; l < LANES; l++)
      hit[l] = pend_i[l] && (addr_i[l][BBITS-1:0] == BBITS'(BANK_ID));
    // Lowest pending lane picks the word served this cycle
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && !acc_o) begin
        acc_o = 1'b1;
        word  = addr_i[l];
      end
    end
    served_o = '0;
    for (int l = 0; l < LANES; l++)
      served_o[l] = hit[l] && (addr_i[l] == word);
    // Highest-index writer to the word wins
    wsel = '0;
    wr_o = 1'b0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (served_o[l] && we_i[l] && !wr_o) begin
        wsel[l] = 1'b1;
        wr_o    = 1'b1;
      end
    end
    wdata_o = '0;
    for (int l = 0; l < LANES; l++)
      if (wsel[l]) wdata_o = wdata_i[l];
  end

  assign row_o = word[AW-1:BBITS];

  p_bank_progress_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit) |-> (|served_o));
  p_one_writer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wsel));
endmodule

// File: rtl/smem_bank_arb.sv
module smem_bank_arb #(
  parameter int unsigned LANES = smem_pkg::DEF_LANES,
  parameter int unsigned BANKS = smem_pkg::DEF_BANKS,
  parameter int unsigned DW    = smem_pkg::DEF_DW,
  parameter int unsigned AW    = smem_pkg::DEF_AW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [LANES-1:0]         lane_vld_i,
  input  logic [LANES-1:0][AW-1:0] lane_addr_i,
  input  logic [LANES-1:0]         lane_we_i,
  input  logic [LANES-1:0][DW-1:0] lane_wdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [LANES-1:0][DW-1:0] rd_data_o
);
  localparam int unsigned BBITS = $clog2(BANKS);
  localparam int unsigned RW    = AW - BBITS;
  localparam int unsigned DEPTH = 1 << RW;
  localparam int unsigned CW    = $clog2(LANES) + 1;

  logic                     busy_q, done_q;
  logic [LANES-1:0]         pend_q;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0]         we_q;
  logic [LANES-1:0][DW-1:0] wdata_q;
  logic [LANES-1:0][DW-1:0] rdata_q;
  logic [CW-1:0]            run_q;

  logic [BANKS-1:0][LANES-1:0] served_b;
  logic [BANKS-1:0][DW-1:0]    bank_rdata;
  logic [LANES-1:0]            served;
  logic                        accept;
  logic                        last;

  assign accept = req_i && !busy_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic          acc, wr;
    logic [RW-1:0] row;
    logic [DW-1:0] wd;

    smem_bank_sel #(
      .LANES(LANES), .AW(AW), .DW(DW), .BBITS(BBITS), .BANK_ID(b)
    ) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pend_i  (pend_q),
      .addr_i  (addr_q),
      .we_i    (we_q),
      .wdata_i (wdata_q),
      .acc_o   (acc),
      .row_o   (row),
      .served_o(served_b[b]),
      .wr_o    (wr),
      .wdata_o (wd)
    );

    smem_bank_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk_i  (clk_i),
      .we_i   (busy_q && acc && wr),
      .row_i  (row),
      .wdata_i(wd),
      .rdata_o(bank_rdata[b])
    );
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) served = served | served_b[b];
  end

  assign last = ((pend_q & ~served) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      we_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      run_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      pend_q  <= lane_vld_i;
      addr_q  <= lane_addr_i;
      we_q    <= lane_we_i;
      wdata_q <= lane_wdata_i;
      rdata_q <= '0;
      run_q   <= '0;
    end else if (busy_q) begin
      pend_q <= pend_q & ~served;
      run_q  <= run_q + 1'b1;
      for (int l = 0; l < LANES; l++)
        if (served[l] && !we_q[l])
          rdata_q[l] <= bank_rdata[addr_q[l][BBITS-1:0]];
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rd_data_o = rdata_q;

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_on_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  p_progress_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && pend_q != '0) |=> ($countones(pend_q) < $past($countones(pend_q))));
  p_cost_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (run_q < CW'(LANES)));
  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_i) |=> ($stable(addr_q) && $stable(we_q) && $stable(wdata_q)));
endmodule

// File: tb/sim_smem_bank_arb.sv
module sim_smem_bank_arb;
  localparam int LANES = 16;
  localparam int BANKS = 16;
  localparam int DW    = 32;
  localparam int AW    = 10;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                     req;
  logic [LANES-1:0]         vld;
  logic [LANES-1:0][AW-1:0] addr;
  logic [LANES-1:0]         we;
  logic [LANES-1:0][DW-1:0] wdata;
  logic                     busy_o, done_o;
  logic [LANES-1:0][DW-1:0] rd_data_o;

  smem_bank_arb #(.LANES(LANES), .BANKS(BANKS), .DW(DW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .lane_vld_i(vld), .lane_addr_i(addr), .lane_we_i(we), .lane_wdata_i(wdata),
    .busy_o(busy_o), .done_o(done_o), .rd_data_o(rd_data_o)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl [WORDS];

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_cost();
    int cnt [BANKS];
    int mx = 0;
    for (int b = 0; b < BANKS; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      bit seen = 1'b0;
      if (!vld[l]) continue;
      for (int k = 0; k < l; k++)
        if (vld[k] && addr[k] == addr[l]) seen = 1'b1;
      if (!seen) cnt[addr[l] % BANKS]++;
    end
    for (int b = 0; b < BANKS; b++) if (cnt[b] > mx) mx = cnt[b];
    return (mx == 0) ? 1 : mx;
  endfunction

  // Runs the group currently on the lane inputs; inject raises req mid-group
  task automatic go(input string rq, input bit inject, input logic [AW-1:0] inj_addr);
    logic [DW-1:0] exp_rd [LANES];
    logic [LANES-1:0] lv, lw;
    logic [LANES-1:0][AW-1:0] la;
    logic [LANES-1:0][DW-1:0] ld;
    int ec, n;
    ec = exp_cost();
    lv = vld; lw = we; la = addr; ld = wdata;
    for (int l = 0; l < LANES; l++)
      exp_rd[l] = (lv[l] && !lw[l]) ? mdl[la[l]] : '0;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    n = 0;
    while (busy_o && n < LANES + 4) begin
      n++;
      if (inject && n == 1) begin
        vld = '1; we = '1;
        for (int l = 0; l < LANES; l++) begin
          addr[l] = inj_addr; wdata[l] = 32'hDEAD_0000 + l;
        end
        req = 1'b1;
      end
      @(negedge clk);
      req = 1'b0;
    end
    chk(n == ec, rq, "busy cycles", n, ec);
    chk(done_o == 1'b1, rq, "done pulse", done_o, 1);
    for (int l = 0; l < LANES; l++)
      chk(rd_data_o[l] === exp_rd[l], rq, $sformatf("lane %0d data", l), rd_data_o[l], exp_rd[l]);
    for (int l = 0; l < LANES; l++)
      if (lv[l] && lw[l]) mdl[la[l]] = ld[l];
    @(negedge clk);
    chk(done_o == 1'b0, "R3", "done single pulse", done_o, 0);
  endtask

  task automatic set_stride(input int base, input int stride, input bit wr, input int seed);
    vld = '1;
    we  = wr ? '1 : '0;
    for (int l = 0; l < LANES; l++) begin
      addr[l]  = AW'((base + stride * l) % WORDS);
      wdata[l] = 32'h5A00_0000 + seed * 256 + l;
    end
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    chk(rd_data_o == '0, "R1", "rd_data after reset", 0, 0);
  endtask

  task automatic t_fill();
    for (int g = 0; g < WORDS / LANES; g++) begin
      set_stride(g * LANES, 1, 1'b1, g);
      go("R2", 1'b0, '0);
    end
  endtask

  task automatic t_linear_read();
    set_stride(37, 1, 1'b0, 0);
    go("R2", 1'b0, '0);
  endtask

  task automatic t_odd_stride();
    set_stride(5, 3, 1'b0, 0);
    go("R5", 1'b0, '0);
    set_stride(2, 7, 1'b0, 0);
    go("R5", 1'b0, '0);
  endtask

  task automatic t_stride2();
    set_stride(100, 2, 1'b1, 300);
    go("R5", 1'b0, '0);
    set_stride(100, 2, 1'b0, 0);
    go("R5", 1'b0, '0);
  endtask

  task automatic t_stride8();
    set_stride(1, 8, 1'b0, 0);
    go("R5", 1'b0, '0);
  endtask

  task automatic t_broadcast();
    set_stride(77, 0, 1'b0, 0);
    go("R4", 1'b0, '0);
    chk(rd_data_o[LANES-1] === mdl[77], "R4", "broadcast word", rd_data_o[LANES-1], mdl[77]);
  endtask

  task automatic t_write_clash();
    set_stride(0, 1, 1'b0, 0);
    vld = '0;
    vld[3] = 1'b1; vld[9] = 1'b1;
    we[3] = 1'b1; we[9] = 1'b1;
    addr[3] = 200; addr[9] = 200;
    wdata[3] = 32'h0000_0111; wdata[9] = 32'h0000_0222;
    go("R6", 1'b0, '0);
    set_stride(200, 0, 1'b0, 0);
    vld = 16'h0001;
    go("R6", 1'b0, '0);
    chk(rd_data_o[0] === 32'h0000_0222, "R6", "higher lane write kept", rd_data_o[0], 32'h222);
  endtask

  task automatic t_read_vs_write();
    logic [DW-1:0] old;
    old = mdl[300];
    set_stride(0, 1, 1'b0, 0);
    vld = '0;
    vld[2] = 1'b1; vld[5] = 1'b1;
    addr[2] = 300; addr[5] = 300;
    we[5] = 1'b1; wdata[5] = 32'hC0DE_0300;
    go("R7", 1'b0, '0);
    chk(rd_data_o[2] === old, "R7", "read returns prior value", rd_data_o[2], old);
    chk(rd_data_o[5] === '0, "R8", "write lane reads zero", rd_data_o[5], 0);
    set_stride(300, 0, 1'b0, 0);
    vld = 16'h0001;
    go("R7", 1'b0, '0);
  endtask

  task automatic t_masked();
    set_stride(0, 16, 1'b1, 900);
    vld = '0;
    vld[0] = 1'b1; vld[4] = 1'b1;
    go("R10", 1'b0, '0);
    set_stride(0, 16, 1'b0, 0);
    vld = '0;
    go("R10", 1'b0, '0);
    set_stride(0, 16, 1'b0, 0);
    vld = 16'h0011;
    go("R8", 1'b0, '0);
    chk(rd_data_o[1] === '0, "R8", "invalid lane reads zero", rd_data_o[1], 0);
    chk(mdl[16] !== 32'h5A00_0000 + 900 * 256 + 1, "R10", "model untouched", 0, 0);
  endtask

  task automatic t_busy_ignored();
    set_stride(3, 8, 1'b0, 0);
    go("R9", 1'b1, AW'(500));
    set_stride(500, 0, 1'b0, 0);
    vld = 16'h0001;
    go("R9", 1'b0, '0);
    chk(rd_data_o[0] === mdl[500], "R9", "word not overwritten", rd_data_o[0], mdl[500]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req = 1'b0; vld = '0; we = '0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_linear_read();
    t_odd_stride();
    t_stride2();
    t_stride8();
    t_broadcast();
    t_write_clash();
    t_read_vs_write();
    t_masked();
    t_busy_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule